// File: doc/BRIEF.md
# Branch Trace Lookahead Cache

This block is a small direct-mapped table that maps one branch, together with the direction taken and the target, to the next branch that execution reaches along that path. A lookahead engine uses it to step from one basic block to the next without fetching any instructions. The engine sends the next-branch address it receives to a branch predictor. The predicted outcome comes back as a new lookup, and the walk continues until the table misses.

Training comes from retirement. Each retired branch pair gives the current branch address, its direction, its target and the address of the branch that followed. Every slot holds three things: the low part of the branch address (used as a tag), the low part of the following branch address, and a two-bit confidence state. A disagreeing training event first weakens a confident slot. Only a second disagreement replaces the slot, so a single odd path does not destroy a useful link. A lookup returns hit or miss and the stored next-branch address one cycle after it is presented.

Top module: `brlink_cache`

## Requirements
- R1: Synchronous reset leaves every slot invalid, so the first lookup after reset misses. rsp_valid_o is 0 in the cycle after any cycle with rst high.
- R2: A lookup presented in cycle N with lk_valid_i=1 gives rsp_valid_o=1 in cycle N+1. rsp_valid_o is 0 after any cycle without a lookup. rsp_hit_o is never 1 while rsp_valid_o is 0.
- R3: The slot index is the XOR of address bits [9:2], target bits [9:2] and the direction bit copied into all 8 index bits (taken=1). So a lookup that differs from a trained triple only in direction uses a different slot. A differently addressed triple whose hash folds onto the same slot shares it.
- R4: Training a triple into an invalid slot installs it in the weak state. A later lookup with the same address, direction and target then hits and returns bits [31:0] of the trained next-branch address.
- R5: A hit requires the stored tag to equal bits [31:0] of the lookup address. An address with the same index but different low 32 bits misses. An address that differs only above bit 31 hits.
- R6: Training a slot with a matching tag and a matching next address moves weak to strong. Strong stays strong.
- R7: Training a strong slot with a different tag or next address lowers it to weak and keeps its tag and next address.
- R8: Training a weak slot with a different tag or next address replaces both fields with the new ones and leaves the slot weak.
- R9: A lookup that misses returns rsp_next_o = 0.
- R10: When a lookup and a training event hit the same slot in the same cycle, the lookup answer reflects the slot contents from before that training.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trn_valid_i | input | 1 | Training event this cycle |
| trn_pc_i | input | 43 | Retired branch address |
| trn_taken_i | input | 1 | Retired branch direction (1 = taken) |
| trn_target_i | input | 43 | Retired branch target |
| trn_next_i | input | 43 | Address of the branch that followed |
| lk_valid_i | input | 1 | Lookup request this cycle |
| lk_pc_i | input | 43 | Branch address to look up |
| lk_taken_i | input | 1 | Predicted direction (1 = taken) |
| lk_target_i | input | 43 | Branch target for the lookup |
| rsp_valid_o | output | 1 | Lookup answer valid (one cycle after request) |
| rsp_hit_o | output | 1 | Lookup hit |
| rsp_next_o | output | 32 | Low 32 bits of the next branch address, zero on miss |

## Verification
The bench builds the block with its default of 256 slots, an 8-bit index and 43-bit addresses with 32-bit stored fields. At this size the hash can be steered by hand. One triple is placed so that its direction-flipped hash lands on the slot of another triple, and addresses are chosen that alias on index but not on tag, or differ only above bit 31. Together these make index folding, tag checking and the weak/strong replacement sequence observable through lookup answers alone.

// File: rtl/brlink_pkg.sv
package brlink_pkg;

    localparam int ADDR_W   = 43;
    localparam int TAG_W    = 32;
    localparam int IDX_LSB  = 2;

    typedef enum logic [1:0] {
        ST_INV    = 2'b00,
        ST_WEAK   = 2'b01,
        ST_STRONG = 2'b10
    } conf_e;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [TAG_W-1:0] nxt;
        conf_e            st;
    } slot_t;

    function automatic logic slot_live(input conf_e s);
        return (s == ST_WEAK) || (s == ST_STRONG);
    endfunction

endpackage

// File: rtl/brlink_hash.sv
module brlink_hash
    import brlink_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] tgt_i,
    input  logic              dir_i,
    output logic [IDX_W-1:0]  idx_o
);
    for (genvar b = 0; b < IDX_W; b++) begin : g_fold
        assign idx_o[b] = pc_i[b+IDX_LSB] ^ tgt_i[b+IDX_LSB] ^ dir_i;
    end
endmodule

// File: rtl/brlink_store.sv
module brlink_store
    import brlink_pkg::*;
#(
    parameter int ENTRIES = 256,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i,
    input  logic [IDX_W-1:0] widx_i,
    input  slot_t            wdata_i,
    input  logic [IDX_W-1:0] ridx_lk_i,
    input  logic [IDX_W-1:0] ridx_tr_i,
    output slot_t            rdata_lk_o,
    output slot_t            rdata_tr_o
);
    slot_t mem_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < ENTRIES; e++) begin
                mem_q[e] <= '0;
            end
        end else if (we_i) begin
            mem_q[widx_i] <= wdata_i;
        end
    end

    assign rdata_lk_o = mem_q[ridx_lk_i];
    assign rdata_tr_o = mem_q[ridx_tr_i];
endmodule

// File: rtl/brlink_update.sv
module brlink_update
    import brlink_pkg::*;
(
    input  slot_t            cur_i,
    input  logic [TAG_W-1:0] tag_i,
    input  logic [TAG_W-1:0] nxt_i,
    output slot_t            new_o
);
    logic agree;

    always_comb begin
        agree = (cur_i.tag == tag_i) && (cur_i.nxt == nxt_i);
        new_o = cur_i;
        unique case (cur_i.st)
            ST_STRONG: begin
                if (!agree) new_o.st = ST_WEAK;
            end
            ST_WEAK: begin
                if (agree) begin
                    new_o.st = ST_STRONG;
                end else begin
                    new_o.tag = tag_i;
                    new_o.nxt = nxt_i;
                end
            end
            default: begin
                new_o.tag = tag_i;
                new_o.nxt = nxt_i;
                new_o.st  = ST_WEAK;
            end
        endcase
    end
endmodule

// File: rtl/brlink_cache.sv
module brlink_cache
    import brlink_pkg::*;
#(
    parameter int ENTRIES = 256,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trn_valid_i,
    input  logic [ADDR_W-1:0] trn_pc_i,
    input  logic              trn_taken_i,
    input  logic [ADDR_W-1:0] trn_target_i,
    input  logic [ADDR_W-1:0] trn_next_i,
    input  logic              lk_valid_i,
    input  logic [ADDR_W-1:0] lk_pc_i,
    input  logic              lk_taken_i,
    input  logic [ADDR_W-1:0] lk_target_i,
    output logic              rsp_valid_o,
    output logic              rsp_hit_o,
    output logic [TAG_W-1:0]  rsp_next_o
);
    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] tr_idx;
    slot_t            lk_slot;
    slot_t            tr_slot;
    slot_t            tr_new;
    logic             lk_match;

    brlink_hash #(.IDX_W(IDX_W)) u_lk_hash (
        .pc_i  (lk_pc_i),
        .tgt_i (lk_target_i),
        .dir_i (lk_taken_i),
        .idx_o (lk_idx)
    );

    brlink_hash #(.IDX_W(IDX_W)) u_tr_hash (
        .pc_i  (trn_pc_i),
        .tgt_i (trn_target_i),
        .dir_i (trn_taken_i),
        .idx_o (tr_idx)
    );

    brlink_store #(.ENTRIES(ENTRIES)) u_store (
        .clk        (clk),
        .rst        (rst),
        .we_i       (trn_valid_i),
        .widx_i     (tr_idx),
        .wdata_i    (tr_new),
        .ridx_lk_i  (lk_idx),
        .ridx_tr_i  (tr_idx),
        .rdata_lk_o (lk_slot),
        .rdata_tr_o (tr_slot)
    );

    brlink_update u_update (
        .cur_i (tr_slot),
        .tag_i (trn_pc_i[TAG_W-1:0]),
        .nxt_i (trn_next_i[TAG_W-1:0]),
        .new_o (tr_new)
    );

    assign lk_match = slot_live(lk_slot.st) && (lk_slot.tag == lk_pc_i[TAG_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_o <= 1'b0;
            rsp_hit_o   <= 1'b0;
            rsp_next_o  <= '0;
        end else begin
            rsp_valid_o <= lk_valid_i;
            rsp_hit_o   <= lk_valid_i && lk_match;
            rsp_next_o  <= (lk_valid_i && lk_match) ? lk_slot.nxt : '0;
        end
    end
endmodule

// File: rtl/brlink_checker.sv
module brlink_checker
    import brlink_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             lk_valid_i,
    input logic             trn_valid_i,
    input slot_t            tr_new,
    input logic             rsp_valid_o,
    input logic             rsp_hit_o,
    input logic [TAG_W-1:0] rsp_next_o
);
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        rst |=> !rsp_valid_o);

    p_answer_follows_request_r2: assert property (@(posedge clk) disable iff (rst)
        lk_valid_i |=> rsp_valid_o);

    p_no_answer_without_request_r2: assert property (@(posedge clk) disable iff (rst)
        !lk_valid_i |=> !rsp_valid_o);

    p_hit_needs_valid_r2: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid_o |-> !rsp_hit_o);

    p_miss_zero_next_r9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid_o && !rsp_hit_o) |-> (rsp_next_o == '0));

    p_write_never_invalid_r4: assert property (@(posedge clk) disable iff (rst)
        trn_valid_i |-> slot_live(tr_new.st));
endmodule

bind brlink_cache brlink_checker u_checker (
    .clk         (clk),
    .rst         (rst),
    .lk_valid_i  (lk_valid_i),
    .trn_valid_i (trn_valid_i),
    .tr_new      (tr_new),
    .rsp_valid_o (rsp_valid_o),
    .rsp_hit_o   (rsp_hit_o),
    .rsp_next_o  (rsp_next_o)
);

// File: tb/brlink_cache_tb.sv
module brlink_cache_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 43;

    localparam logic [AW-1:0] A_PC  = 43'h0_1000_0100;
    localparam logic [AW-1:0] A_TG  = 43'h0_1000_0200;
    localparam logic [AW-1:0] B_PC  = 43'h0_2000_00FC;
    localparam logic [AW-1:0] B_TG  = 43'h0_2000_0000;
    localparam logic [AW-1:0] C_PC  = 43'h0_3000_0010;
    localparam logic [AW-1:0] C_TG  = 43'h0_3000_0020;
    localparam logic [AW-1:0] N1    = 43'h0_1000_0300;
    localparam logic [AW-1:0] N2    = 43'h0_1000_0400;
    localparam logic [AW-1:0] N3    = 43'h0_0000_0500;
    localparam logic [AW-1:0] NB    = 43'h0_2000_1000;
    localparam logic [AW-1:0] NC    = 43'h0_3000_0800;
    localparam logic [AW-1:0] ALIAS = 43'h0_1010_0100;
    localparam logic [AW-1:0] HIGH  = 43'h100_1000_0100;

    typedef struct packed {
        logic          is_lk;
        logic [AW-1:0] pc;
        logic          dir;
        logic [AW-1:0] tgt;
        logic [AW-1:0] nxt;
        logic          hit;
        logic [31:0]   exp;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b1, A_PC,  1'b0, A_TG, '0, 1'b0, 32'h0,         4'd1}, // R1 R9 empty table
        '{1'b0, A_PC,  1'b0, A_TG, N1, 1'b0, 32'h0,         4'd4}, // R4 install
        '{1'b1, A_PC,  1'b0, A_TG, '0, 1'b1, 32'h1000_0300, 4'd4}, // R4 hit
        '{1'b1, A_PC,  1'b1, A_TG, '0, 1'b0, 32'h0,         4'd3}, // R3 other direction
        '{1'b1, ALIAS, 1'b0, A_TG, '0, 1'b0, 32'h0,         4'd5}, // R5 alias miss
        '{1'b1, HIGH,  1'b0, A_TG, '0, 1'b1, 32'h1000_0300, 4'd5}, // R5 high bits ignored
        '{1'b0, A_PC,  1'b0, A_TG, N2, 1'b0, 32'h0,         4'd8}, // R8 weak replaced
        '{1'b1, A_PC,  1'b0, A_TG, '0, 1'b1, 32'h1000_0400, 4'd8},
        '{1'b0, A_PC,  1'b0, A_TG, N2, 1'b0, 32'h0,         4'd6}, // R6 strengthen
        '{1'b0, A_PC,  1'b0, A_TG, N3, 1'b0, 32'h0,         4'd7}, // R7 strong lowered
        '{1'b1, A_PC,  1'b0, A_TG, '0, 1'b1, 32'h1000_0400, 4'd7}, // R7 old next kept
        '{1'b0, A_PC,  1'b0, A_TG, N3, 1'b0, 32'h0,         4'd8}, // R8 replace after weaken
        '{1'b1, A_PC,  1'b0, A_TG, '0, 1'b1, 32'h0000_0500, 4'd8},
        '{1'b0, B_PC,  1'b1, B_TG, NB, 1'b0, 32'h0,         4'd3}, // R3 folds onto A slot
        '{1'b1, A_PC,  1'b0, A_TG, '0, 1'b0, 32'h0,         4'd3}, // R3 A evicted
        '{1'b1, B_PC,  1'b1, B_TG, '0, 1'b1, 32'h2000_1000, 4'd3}  // R3 B present
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          trn_valid_i, trn_taken_i, lk_valid_i, lk_taken_i;
    logic [AW-1:0] trn_pc_i, trn_target_i, trn_next_i, lk_pc_i, lk_target_i;
    logic          rsp_valid_o, rsp_hit_o;
    logic [31:0]   rsp_next_o;

    int checks   = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    brlink_cache u_dut (
        .clk          (clk),
        .rst          (rst),
        .trn_valid_i  (trn_valid_i),
        .trn_pc_i     (trn_pc_i),
        .trn_taken_i  (trn_taken_i),
        .trn_target_i (trn_target_i),
        .trn_next_i   (trn_next_i),
        .lk_valid_i   (lk_valid_i),
        .lk_pc_i      (lk_pc_i),
        .lk_taken_i   (lk_taken_i),
        .lk_target_i  (lk_target_i),
        .rsp_valid_o  (rsp_valid_o),
        .rsp_hit_o    (rsp_hit_o),
        .rsp_next_o   (rsp_next_o)
    );

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        trn_valid_i = 1'b0; trn_taken_i = 1'b0; trn_pc_i = '0; trn_target_i = '0; trn_next_i = '0;
        lk_valid_i = 1'b0; lk_taken_i = 1'b0; lk_pc_i = '0; lk_target_i = '0;
    endtask

    task automatic check_rsp(input string req, input logic ev, input logic eh, input logic [31:0] en);
        check(rsp_valid_o == ev, {req, " valid"}, 64'(rsp_valid_o), 64'(ev));
        check(rsp_hit_o == eh, {req, " hit"}, 64'(rsp_hit_o), 64'(eh));
        check(rsp_next_o == en, {req, " next"}, 64'(rsp_next_o), 64'(en));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_rsp("R1 reset", 1'b0, 1'b0, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            lk_valid_i   = VECS[i].is_lk;
            trn_valid_i  = !VECS[i].is_lk;
            lk_pc_i      = VECS[i].pc;  trn_pc_i     = VECS[i].pc;
            lk_taken_i   = VECS[i].dir; trn_taken_i  = VECS[i].dir;
            lk_target_i  = VECS[i].tgt; trn_target_i = VECS[i].tgt;
            trn_next_i   = VECS[i].nxt;
            @(negedge clk);
            idle_inputs();
            check_rsp($sformatf("R%0d vec%0d", VECS[i].req, i),
                      VECS[i].is_lk, VECS[i].hit, VECS[i].exp);
        end

        // R10: same-cycle train and lookup see the old (invalid) slot
        trn_valid_i = 1'b1; trn_pc_i = C_PC; trn_target_i = C_TG; trn_next_i = NC;
        lk_valid_i  = 1'b1; lk_pc_i  = C_PC; lk_target_i  = C_TG;
        @(negedge clk);
        idle_inputs();
        check_rsp("R10 same cycle", 1'b1, 1'b0, 32'h0);
        // R2: idle cycle gives no answer
        @(negedge clk);
        check_rsp("R2 idle", 1'b0, 1'b0, 32'h0);
        lk_valid_i = 1'b1; lk_pc_i = C_PC; lk_target_i = C_TG;
        @(negedge clk);
        idle_inputs();
        check_rsp("R10 after write", 1'b1, 1'b1, 32'h3000_0800);

        // R1: reset in mid-run clears slots and answers
        lk_valid_i = 1'b1; lk_pc_i = B_PC; lk_taken_i = 1'b1; lk_target_i = B_TG;
        rst = 1'b1;
        @(negedge clk);
        check_rsp("R1 during reset", 1'b0, 1'b0, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        idle_inputs();
        check_rsp("R1 slots cleared", 1'b1, 1'b0, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule